// File: doc/BRIEF.md
# Configurable Registered Fan-out Buffer

This block is one register stage for the command and address lines of a memory module. On each rising clock edge it samples up to `WIDE_W` input bits and drives them from output flops. Two static configuration inputs pick how the inputs map to the outputs. In the straight mode every input bit has one output. In the duplicating mode only the low `NARROW_W` inputs are used, and each of them drives two output positions. In that mode the second configuration bit chooses between two fixed layouts of the copies.

Two active-low chip-select inputs save switching power. While both are high, the output flops keep their values. If either one is low, the outputs load new data on every edge. Tying one select low makes the block a plain pipeline stage. An asynchronous active-low reset clears the outputs at once, with no clock needed, and it wins over the gating.

The output bus is `OUT_W = max(WIDE_W, 2*NARROW_W)` bits wide. Any position that the selected mode does not use is driven low.

Top module: `fanbuf_top`

## Requirements
- R1: With `cfg_dup_i`=0, `q_o[i]` takes the value of `d_i[i]` from the rising clock edge (for i < WIDE_W) and changes at no other time.
- R2: With `cfg_dup_i`=0, the output bits `q_o[OUT_W-1:WIDE_W]` stay 0.
- R3: With `cfg_dup_i`=1 and `cfg_alt_i`=0 (layout A), `q_o[i]` and `q_o[NARROW_W+i]` both carry the captured `d_i[i]`, for i < NARROW_W.
- R4: With `cfg_dup_i`=1 and `cfg_alt_i`=1 (layout B), `q_o[2i]` and `q_o[2i+1]` both carry the captured `d_i[i]`, for i < NARROW_W.
- R5: At a rising edge where `cs0_ni`=1 and `cs1_ni`=1, `q_o` keeps its previous value.
- R6: At a rising edge where `cs0_ni`=0 or `cs1_ni`=0, `q_o` loads the newly mapped data.
- R7: While `rst_ni`=0, `q_o` is all zeros. It clears without waiting for a clock edge, even when both selects are high.
- R8: When reset is released while `d_i` is all zeros and the clock runs, `q_o` stays all zeros.
- R9: In the duplicating modes, `d_i[WIDE_W-1:NARROW_W]` has no effect on `q_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Capture clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_dup_i | input | 1 | 0: straight mode, 1: duplicating mode (static) |
| cfg_alt_i | input | 1 | Copy layout in duplicating mode: 0 = A, 1 = B (static) |
| cs0_ni | input | 1 | Chip select 0, active low |
| cs1_ni | input | 1 | Chip select 1, active low |
| d_i | input | WIDE_W | Data inputs |
| q_o | output | OUT_W | Registered outputs |

## Verification
The bench builds the block with WIDE_W=25 and NARROW_W=14, which gives a 28-bit output bus. The straight mode therefore leaves three top bits that must read zero. The two copy layouts also place the copies at different positions across the whole bus, so a swapped or shifted index shows up. Toggling the upper inputs while in duplicating mode tests that those inputs are ignored. Reset is pulled mid-cycle while gating is active, and it is released with all inputs at zero.

// File: rtl/fanbuf_pkg.sv
package fanbuf_pkg;
  typedef enum logic [1:0] {
    MODE_WIDE  = 2'd0,
    MODE_DUP_A = 2'd1,
    MODE_DUP_B = 2'd2
  } fan_mode_e;

  function automatic fan_mode_e decode_mode(input logic dup, input logic alt);
    if (!dup)    return MODE_WIDE;
    else if (alt) return MODE_DUP_B;
    else          return MODE_DUP_A;
  endfunction
endpackage

// File: rtl/fanbuf_map.sv
module fanbuf_map
  import fanbuf_pkg::*;
#(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14,
  parameter int OUT_W    = 28
) (
  input  fan_mode_e         mode_i,
  input  logic [WIDE_W-1:0] d_i,
  output logic [OUT_W-1:0]  q_o
);
  always_comb begin
    q_o = '0;
    unique case (mode_i)
      MODE_WIDE: begin
        for (int i = 0; i < WIDE_W; i++) q_o[i] = d_i[i];
      end
      MODE_DUP_A: begin
        for (int i = 0; i < NARROW_W; i++) begin
          q_o[i]          = d_i[i];
          q_o[NARROW_W+i] = d_i[i];
        end
      end
      MODE_DUP_B: begin
        for (int i = 0; i < NARROW_W; i++) begin
          q_o[2*i]   = d_i[i];
          q_o[2*i+1] = d_i[i];
        end
      end
      default: q_o = '0;
    endcase
  end
endmodule

// File: rtl/fanbuf_gate.sv
module fanbuf_gate (
  input  logic cs0_ni,
  input  logic cs1_ni,
  output logic upd_o
);
  // freeze only when both selects are deasserted
  assign upd_o = ~(cs0_ni & cs1_ni);
endmodule

// File: rtl/fanbuf_oreg.sv
module fanbuf_oreg #(
  parameter int W = 28
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end

  a_r5_hold_when_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o));
  a_r6_load_when_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> q_o == $past(d_i));
endmodule

// File: rtl/fanbuf_top.sv
module fanbuf_top
  import fanbuf_pkg::*;
#(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14,
  localparam int OUT_W   = (2*NARROW_W > WIDE_W) ? 2*NARROW_W : WIDE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_dup_i,
  input  logic              cfg_alt_i,
  input  logic              cs0_ni,
  input  logic              cs1_ni,
  input  logic [WIDE_W-1:0] d_i,
  output logic [OUT_W-1:0]  q_o
);
  fan_mode_e        mode;
  logic [OUT_W-1:0] mapped;
  logic             upd;

  assign mode = decode_mode(cfg_dup_i, cfg_alt_i);

  fanbuf_map #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .OUT_W(OUT_W)) u_map (
    .mode_i(mode), .d_i(d_i), .q_o(mapped)
  );

  fanbuf_gate u_gate (.cs0_ni(cs0_ni), .cs1_ni(cs1_ni), .upd_o(upd));

  fanbuf_oreg #(.W(OUT_W)) u_oreg (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(upd), .d_i(mapped), .q_o(q_o)
  );

  if (OUT_W > WIDE_W) begin : g_gap_chk
    a_r2_upper_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_dup_i |-> q_o[OUT_W-1:WIDE_W] == '0);
  end

  a_r3_layout_a_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_dup_i && !cfg_alt_i) |-> q_o[NARROW_W-1:0] == q_o[2*NARROW_W-1:NARROW_W]);

  for (genvar g = 0; g < NARROW_W; g++) begin : g_pair_chk
    a_r4_layout_b_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_dup_i && cfg_alt_i) |-> q_o[2*g] == q_o[2*g+1]);
  end

  a_r9_upper_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_dup_i && upd && $stable(d_i[NARROW_W-1:0]) && $past(upd)) |=> $stable(q_o));
endmodule

// File: tb/fanbuf_top_bench.sv
module fanbuf_top_bench;
  localparam int WW = 25;
  localparam int NW = 14;
  localparam int OW = 28;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_dup_i = 1'b0, cfg_alt_i = 1'b0;
  logic          cs0_ni = 1'b1, cs1_ni = 1'b1;
  logic [WW-1:0] d_i = '0;
  logic [OW-1:0] q_o;

  int n_run = 0, n_fail = 0;
  logic [OW-1:0] exp_q[$];
  string         tag_q[$];
  logic [OW-1:0] model = '0;
  bit            done = 0;

  fanbuf_top #(.WIDE_W(WW), .NARROW_W(NW)) u_fanbuf_top (.*);

  always #10 clk_i = ~clk_i;

  function automatic logic [OW-1:0] ref_map(logic [WW-1:0] d, logic dup, logic alt);
    logic [OW-1:0] r = '0;
    if (!dup) r[WW-1:0] = d;
    else if (!alt) begin
      r[NW-1:0] = d[NW-1:0];
      r[2*NW-1:NW] = d[NW-1:0];
    end else
      for (int i = 0; i < NW; i++) begin
        r[2*i] = d[i];
        r[2*i+1] = d[i];
      end
    return r;
  endfunction

  task automatic check(string tag, logic [OW-1:0] act, logic [OW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [WW-1:0] d, logic c0, logic c1, string tag);
    @(negedge clk_i);
    d_i = d; cs0_ni = c0; cs1_ni = c1;
    if (!(c0 && c1)) model = ref_map(d, cfg_dup_i, cfg_alt_i);
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  // reset pulled mid-cycle, selects left high
  task automatic mid_reset(logic dup, logic alt);
    @(posedge clk_i); #5;
    cs0_ni = 1'b1; cs1_ni = 1'b1;
    rst_ni = 1'b0;
    #1 check("R7 async clear under gating", q_o, '0);
    model = '0;
    cfg_dup_i = dup; cfg_alt_i = alt; d_i = '0;
    @(posedge clk_i); #3;
    check("R7 held in reset", q_o, '0);
    @(negedge clk_i); rst_ni = 1'b1;
    drive('0, 1'b0, 1'b0, "R8 release low");
    drive('0, 1'b0, 1'b1, "R8 release low");
  endtask

  always @(posedge clk_i) begin
    #2;
    if (exp_q.size() > 0) check(tag_q.pop_front(), q_o, exp_q.pop_front());
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: got hang expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #15 check("R7 reset state", q_o, '0);
    @(negedge clk_i); rst_ni = 1'b1;
    drive('0, 1'b0, 1'b0, "R8 release low");
    drive('0, 1'b1, 1'b0, "R8 release low");
    // straight mode
    drive(25'h1ABCDEF, 1'b0, 1'b0, "R1 R2 wide");
    drive(25'h0543210, 1'b1, 1'b0, "R6 wide cs0 high");
    drive(25'h1FFFFFF, 1'b0, 1'b1, "R2 wide all ones");
    drive(25'h0AAAAAA, 1'b1, 1'b1, "R5 wide gated");
    drive(25'h1555555, 1'b1, 1'b1, "R5 wide gated");
    drive(25'h1555555, 1'b0, 1'b1, "R6 wide reopen");
    for (int k = 0; k < 6; k++)
      drive(25'(32'h9E3779B9 * (k + 1)), 1'(k[0]), 1'(k[1]), "R1 wide sweep");
    // layout A
    mid_reset(1'b1, 1'b0);
    drive(25'h0001234, 1'b0, 1'b0, "R3 layout A");
    drive(25'h1FFC000 | 25'h0001234, 1'b0, 1'b0, "R9 upper ignored A");
    drive(25'h0003FFF, 1'b1, 1'b0, "R3 layout A ones");
    drive(25'h0002AAA, 1'b1, 1'b1, "R5 layout A gated");
    drive(25'h1FFD555, 1'b0, 1'b1, "R3 R9 layout A");
    // layout B
    mid_reset(1'b1, 1'b1);
    drive(25'h0002001, 1'b0, 1'b0, "R4 layout B");
    drive(25'h0001555, 1'b0, 1'b0, "R4 layout B alt bits");
    drive(25'h1AAD555, 1'b0, 1'b0, "R9 upper ignored B");
    drive(25'h0000F0F, 1'b1, 1'b1, "R5 layout B gated");
    drive(25'h0000F0F, 1'b1, 1'b0, "R6 layout B reopen");
    // back to straight
    mid_reset(1'b0, 1'b0);
    drive(25'h1000001, 1'b0, 1'b0, "R1 R2 wide edges");
    drive('0, 1'b0, 1'b0, "R1 wide zero");
    repeat (3) @(posedge clk_i);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule